// File: doc/BRIEF.md
# Oversampled SPI Mode-3 Slave Front End

This block receives and sends serial frames as an SPI slave in mode 3 (clock idles high, data taken on the rising clock edge, data changed after the falling edge). The serial clock is never used as a clock. All four pins go through a two-flop synchronizer and a deglitch filter into the system clock domain: chip select, serial clock, serial data in and a separate active-low enable. The filter passes a new level only after `FILT_LEN` consecutive equal samples. The serial clock edges are found on the filtered level.

Each frame holds `FRAME_BITS` bits, 40 by default, most significant bit first in both directions. When chip select falls, the parallel `tx_word` is loaded into the transmit shifter, and its top bit appears on `sdo` straight away. When chip select rises, the block checks how many rising clock edges it counted. Exactly `FRAME_BITS` edges give a one-cycle `rx_valid` strobe with the received word. Any other count sets `frame_error` and throws the word away.

Top module: `spi3_slave_os`

## Requirements
- R1: `rx_word` holds the frame's SDI bits, taken at each filtered SCK rising edge. The first bit received lands in bit `FRAME_BITS-1` and the last in bit 0.
- R2: After a frame with exactly `FRAME_BITS` rising SCK edges, `rx_valid` is high for exactly one cycle. It is seen `FILT_LEN+4` cycles after the CSN pin rises.
- R3: A frame with any other rising-edge count produces no strobe, sets `frame_error` to 1 and leaves `rx_word` unchanged. The next good frame clears `frame_error` to 0.
- R4: `tx_word` is captured when CSN falls and its top bit is presented on `sdo` first. Each later bit, in descending order, appears after each falling SCK edge that follows a rising edge. The first falling edge does not shift.
- R5: `sdo_oe` is 1 exactly while the filtered CSN is low, so it is 0 whenever `rx_valid` is 1.
- R6: A pulse on SCK or CSN shorter than `FILT_LEN` system-clock samples has no effect: no bit is lost or added, no frame starts and no frame ends.
- R7: `en_n_clean` follows a steady change on `en_n_pin` `FILT_LEN+3` cycles later and ignores shorter pulses.
- R8: Reset state: `rx_valid`=0, `frame_error`=0, `sdo_oe`=0, `rx_word`=0, `en_n_clean`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin, idles high |
| sdi_pin | input | 1 | Serial data in |
| en_n_pin | input | 1 | Enable pin, active low, filtered only |
| tx_word | input | FRAME_BITS | Reply word, loaded when CSN falls |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for the SDO pad |
| rx_word | output | FRAME_BITS | Last complete received frame |
| rx_valid | output | 1 | One-cycle strobe for a new rx_word |
| frame_error | output | 1 | Last frame had a wrong bit count |
| en_n_clean | output | 1 | Filtered enable |

## Verification
Every pin change reaches the logic `FILT_LEN+3` clock edges later: two synchronizer stages, `FILT_LEN` history stages and the filtered register. The registered results then follow. `rx_valid` and each SDO shift appear `FILT_LEN+4` cycles after the CSN rise or SCK fall on the pin, and `en_n_clean` appears `FILT_LEN+3` cycles after its pin. The driver holds each SCK level for ten cycles, so every SDO bit is settled when it is sampled on the falling clock just before the next SCK rise. The strobe is required to be absent on the cycle before it is due and present on the cycle it is due. `frame_error` is read only after the whole filter delay has passed.

// File: rtl/spi3_slave_os.sv
module spi3_slave_os #(
  parameter int FRAME_BITS = 40,
  parameter int FILT_LEN   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n_pin,
  input  logic                  sck_pin,
  input  logic                  sdi_pin,
  input  logic                  en_n_pin,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic                  sdo,
  output logic                  sdo_oe,
  output logic [FRAME_BITS-1:0] rx_word,
  output logic                  rx_valid,
  output logic                  frame_error,
  output logic                  en_n_clean
);
  localparam int CW  = $clog2(FRAME_BITS + 2);
  localparam int NCH = 4;
  localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);

  logic [NCH-1:0] sync1, sync2, flt, flt_d;
  logic [NCH-1:0][FILT_LEN-1:0] hist;
  logic [FRAME_BITS-1:0] rx_sh, tx_sh;
  logic [CW-1:0] cnt;

  wire [NCH-1:0] pins = {en_n_pin, sdi_pin, sck_pin, cs_n_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
      hist  <= '1;
      flt   <= '1;
      flt_d <= '1;
    end else begin
      sync1 <= pins;
      sync2 <= sync1;
      flt_d <= flt;
      for (int i = 0; i < NCH; i++) begin
        hist[i] <= {hist[i][FILT_LEN-2:0], sync2[i]};
        if (&hist[i])       flt[i] <= 1'b1;
        else if (~|hist[i]) flt[i] <= 1'b0;
      end
    end
  end

  wire cs_hi    = flt[0];
  wire cs_fall  = flt_d[0] & ~flt[0];
  wire cs_rise  = ~flt_d[0] & flt[0];
  wire sck_rise = ~flt_d[1] & flt[1];
  wire sck_fall = flt_d[1] & ~flt[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh       <= '0;
      tx_sh       <= '0;
      cnt         <= '0;
      rx_word     <= '0;
      rx_valid    <= 1'b0;
      frame_error <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (cs_fall) begin
        tx_sh <= tx_word;
        cnt   <= '0;
      end else if (!cs_hi) begin
        if (sck_rise) begin
          rx_sh <= {rx_sh[FRAME_BITS-2:0], flt[2]};
          if (cnt != '1) cnt <= cnt + 1'b1;
        end
        if (sck_fall && cnt != '0)
          tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
      end
      if (cs_rise) begin
        if (cnt == FULL) begin
          rx_word     <= rx_sh;
          rx_valid    <= 1'b1;
          frame_error <= 1'b0;
        end else begin
          frame_error <= 1'b1;
        end
      end
    end
  end

  assign sdo        = cs_hi ? 1'b0 : tx_sh[FRAME_BITS-1];
  assign sdo_oe     = ~cs_hi;
  assign en_n_clean = flt[3];
endmodule

// File: rtl/spi3_slave_os_chk.sv
module spi3_slave_os_chk #(
  parameter int FRAME_BITS = 40
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rx_valid,
  input logic [FRAME_BITS-1:0] rx_word,
  input logic                  frame_error,
  input logic                  sdo_oe
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R2
  AST_WORD_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_word)); // R1
  AST_VALID_CLEARS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !frame_error); // R3
  AST_OE_LOW_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !sdo_oe); // R5
  AST_ERROR_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_error) |-> !sdo_oe); // R3
endmodule

bind spi3_slave_os spi3_slave_os_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
  .frame_error(frame_error), .sdo_oe(sdo_oe)
);

// File: tb/tb_spi3_slave_os.sv
module tb_spi3_slave_os;
  localparam int FB   = 40;
  localparam int FL   = 3;
  localparam int HALF = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic cs_n_pin = 1'b1, sck_pin = 1'b1, sdi_pin = 1'b1, en_n_pin = 1'b1;
  logic [FB-1:0] tx_word = '0;
  logic sdo, sdo_oe, rx_valid, frame_error, en_n_clean;
  logic [FB-1:0] rx_word;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [FB-1:0] exp_q[$];
  logic [FB-1:0] last_good = '0;

  spi3_slave_os #(.FRAME_BITS(FB), .FILT_LEN(FL)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
    .sdi_pin(sdi_pin), .en_n_pin(en_n_pin), .tx_word(tx_word), .sdo(sdo),
    .sdo_oe(sdo_oe), .rx_word(rx_word), .rx_valid(rx_valid),
    .frame_error(frame_error), .en_n_clean(en_n_clean)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected strobe", 64'(rx_word), 64'd0);
      else begin
        logic [FB-1:0] e;
        e = exp_q.pop_front();
        chk(rx_word == e, "R1", 64'(rx_word), 64'(e));
        last_good = e;
      end
    end
  end

  task automatic send(input logic [FB-1:0] mosi, input logic [FB-1:0] miso, input int nbits, input bit glitch);
    @(negedge clk);
    tx_word  = miso;
    cs_n_pin = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(sdo_oe === 1'b1, "R5 oe while selected", 64'(sdo_oe), 64'd1);
    for (int i = 0; i < nbits; i++) begin
      sck_pin = 1'b0;
      sdi_pin = (i < FB) ? mosi[FB-1-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < FB) chk(sdo === miso[FB-1-i], "R4 sdo bit", 64'(sdo), 64'(miso[FB-1-i]));
      sck_pin = 1'b1;
      if (glitch && i == 5) begin
        repeat (4) @(negedge clk);
        sck_pin = 1'b0;
        repeat (2) @(negedge clk);
        sck_pin = 1'b1;
        repeat (HALF-6) @(negedge clk);
      end else if (glitch && i == 20) begin
        repeat (3) @(negedge clk);
        cs_n_pin = 1'b1;
        repeat (2) @(negedge clk);
        cs_n_pin = 1'b0;
        repeat (HALF-5) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
    end
    cs_n_pin = 1'b1;
    if (nbits == FB) begin
      exp_q.push_back(mosi);
      repeat (FL+3) @(negedge clk);
      chk(rx_valid === 1'b0, "R2 strobe early", 64'(rx_valid), 64'd0);
      @(negedge clk);
      chk(rx_valid === 1'b1, "R2 strobe due", 64'(rx_valid), 64'd1);
      @(negedge clk);
      chk(rx_valid === 1'b0, "R2 one cycle", 64'(rx_valid), 64'd0);
      chk(frame_error === 1'b0, "R3 error cleared", 64'(frame_error), 64'd0);
    end else begin
      repeat (FL+6) @(negedge clk);
      chk(frame_error === 1'b1, "R3 error set", 64'(frame_error), 64'd1);
      chk(rx_word == last_good, "R3 word kept", 64'(rx_word), 64'(last_good));
    end
    chk(sdo_oe === 1'b0, "R5 oe after frame", 64'(sdo_oe), 64'd0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_valid === 1'b0,    "R8 rx_valid",    64'(rx_valid), 64'd0);
    chk(frame_error === 1'b0, "R8 frame_error", 64'(frame_error), 64'd0);
    chk(sdo_oe === 1'b0,      "R8 sdo_oe",      64'(sdo_oe), 64'd0);
    chk(rx_word === '0,       "R8 rx_word",     64'(rx_word), 64'd0);
    chk(en_n_clean === 1'b1,  "R8 en_n_clean",  64'(en_n_clean), 64'd1);

    begin
      bit moved = 0;
      en_n_pin = 1'b0;
      repeat (2) @(negedge clk);
      en_n_pin = 1'b1;
      repeat (12) begin
        @(negedge clk);
        if (en_n_clean !== 1'b1) moved = 1;
      end
      chk(!moved, "R7 enable glitch", 64'(moved), 64'd0);
    end
    en_n_pin = 1'b0;
    repeat (FL+2) @(negedge clk);
    chk(en_n_clean === 1'b1, "R7 enable early", 64'(en_n_clean), 64'd1);
    @(negedge clk);
    chk(en_n_clean === 1'b0, "R7 enable due", 64'(en_n_clean), 64'd0);

    send(40'hA5_C3_0F_F0_5A, 40'h3C_96_E1_17_8B, FB, 1'b0);
    send(40'h12_34_56_78_9A, 40'hF0_0F_AA_55_C3, FB, 1'b1);
    send(40'hDE_AD_BE_EF_01, 40'h81_42_24_18_FF, FB-1, 1'b0);
    send(40'h00_00_00_00_01, 40'h80_00_00_00_00, FB, 1'b0);
    send(40'h55_AA_55_AA_55, 40'h01_23_45_67_89, FB+1, 1'b0);
    send(40'hFF_FF_FF_FF_FF, 40'h00_00_00_00_00, FB, 1'b0);

    begin
      bit selected = 0;
      cs_n_pin = 1'b0;
      repeat (2) @(negedge clk);
      cs_n_pin = 1'b1;
      repeat (14) begin
        @(negedge clk);
        if (sdo_oe !== 1'b0) selected = 1;
      end
      chk(!selected, "R6 CSN glitch ignored", 64'(selected), 64'd0);
      chk(frame_error === 1'b0, "R6 no frame end", 64'(frame_error), 64'd0);
    end

    send(40'hC0_FF_EE_12_34, 40'h7E_81_7E_81_7E, FB, 1'b1);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all strobes seen", 64'(exp_q.size()), 64'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule